// File: doc/BRIEF.md
# DMA Command Register Front-End

This block sits between a host processor's memory-mapped register port and a DMA engine. The host builds a transfer request by writing a local-store address, the two halves of a 64-bit effective address, a combined size/tag word and a class/opcode word. The write that lands on the class/opcode word is the commit point. At that moment the block checks the transfer size and the alignment of both addresses. If the check passes and there is room, the command goes into a small first-in first-out command queue.

A readable status word reports the outcome of the most recent commit. The queue presents its oldest entry on a valid/ready dequeue port, where the data mover collects it. 64-bit stores let the host write the two address halves together. A 64-bit store can also write the size/tag word and the class/opcode word together, and that store commits the command in the same cycle.

Reads have no side effects. The read data is a combinational function of the word index. Register word indices are: 0 local-store address, 1 effective-address high, 2 effective-address low, 3 size/tag, 4 class/opcode, 5 status.

Top module: `dma_cmd_frontend`

## Requirements
- R1: After reset the status word reads 0 and `deq_valid` is low.
- R2: A 32-bit write (`reg_wide`=0) stores `reg_wdata[31:0]` into the word at `reg_addr`. A 64-bit write at index 1 stores `reg_wdata[63:32]` as address high and `reg_wdata[31:0]` as address low. A 64-bit write at index 3 stores `reg_wdata[63:32]` as size/tag and uses `reg_wdata[31:0]` as the class/opcode word. A 64-bit write at any other index acts as a 32-bit write.
- R3: A commit is a write to index 4, or a 64-bit write to index 3. It uses the size/tag value written in that same cycle when one is present. A commit that passes the checks and finds room enqueues {local-store address, 64-bit effective address, size, tag, class/opcode} and sets status to 0. The size is bits [31:16] of the size/tag word. The tag is bits [4:0]; the upper tag bits are dropped.
- R4: The only legal sizes are 1, 2, 4 and 8, and nonzero multiples of 16 up to 16384. Any other size, including 0, is rejected with status 2.
- R5: For a size below 16, the low address bits selected by (size-1) must be zero in both the local-store address and the effective-address low word. For a size of 16 or more, bits [3:0] of both addresses must be zero. A violation is rejected with status 2.
- R6: The queue holds 8 entries. A legal commit made while 8 entries are held sets status 1 and is not enqueued. A dequeue in the same cycle does not make room for it.
- R7: When a commit is both illegal and arrives while the queue is full, the status is 2. A rejected commit never changes the queue contents.
- R8: `deq_valid` is high while the queue holds an entry, and the dequeue outputs show the oldest entry. An entry is removed on a clock edge where `deq_valid` and `deq_ready` are both high. Entries leave in commit order.
- R9: A read of index 5 returns the status code in bits [1:0], with zeros above. A read of any other index returns 0. Writes to index 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | Write is a 64-bit store |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| deq_valid | output | 1 | Queue head is valid |
| deq_ready | input | 1 | Consumer takes the head entry |
| deq_lsa | output | 32 | Head local-store address |
| deq_ea | output | 64 | Head effective address |
| deq_size | output | 16 | Head transfer size in bytes |
| deq_tag | output | 5 | Head tag |
| deq_cmd | output | 32 | Head class/opcode word |

## Verification
The hardest case to reach from the ports is a commit that is both illegal and arrives while the queue is full, because the priority between the two rejection codes only shows there. The bench reaches it by holding `deq_ready` low and committing eight aligned commands. It then issues one legal commit, expecting status 1, and one misaligned commit, expecting status 2. It then drains the queue and counts exactly eight entries. A table of size and address combinations covers every branch of the legality check before the queue is ever drained. The drain then checks order and field packing, including tag bits above bit 4 being dropped.

// File: rtl/dma_cmd_frontend.sv
module dma_cmd_frontend #(
  parameter int DEPTH     = 8,
  parameter int MAX_BYTES = 16384,
  parameter int TAG_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_wide,
  input  logic [2:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              deq_valid,
  input  logic              deq_ready,
  output logic [31:0]       deq_lsa,
  output logic [63:0]       deq_ea,
  output logic [15:0]       deq_size,
  output logic [TAG_W-1:0]  deq_tag,
  output logic [31:0]       deq_cmd
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = 32 + 64 + 16 + TAG_W + 32;
  localparam logic [1:0] ST_OK = 2'd0, ST_FULL = 2'd1, ST_BAD = 2'd2;

  logic [31:0] lsa_q, eah_q, eal_q, sztag_q;
  logic [1:0]  status_q;
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  wire wr_lsa = reg_wr && reg_addr == 3'd0;
  wire wr_eah = reg_wr && reg_addr == 3'd1;
  wire wr_eal = reg_wr && (reg_addr == 3'd2 || (reg_addr == 3'd1 && reg_wide));
  wire wr_sz  = reg_wr && reg_addr == 3'd3;
  wire commit = reg_wr && (reg_addr == 3'd4 || (reg_addr == 3'd3 && reg_wide));

  wire [31:0] upper_or_lower = reg_wide ? reg_wdata[63:32] : reg_wdata[31:0];
  wire [31:0] sztag_eff = wr_sz ? upper_or_lower : sztag_q;
  wire [15:0] size      = sztag_eff[31:16];
  wire [3:0]  mask      = size[3:0] - 4'd1;

  wire small_ok = size == 16'd1 || size == 16'd2 || size == 16'd4 || size == 16'd8;
  wire big_ok   = size[3:0] == 4'd0 && size != 16'd0 && {16'd0, size} <= 32'(MAX_BYTES);
  wire small_al = (lsa_q[3:0] & mask) == 4'd0 && (eal_q[3:0] & mask) == 4'd0;
  wire big_al   = lsa_q[3:0] == 4'd0 && eal_q[3:0] == 4'd0;
  wire legal    = (small_ok && small_al) || (big_ok && big_al);

  wire full = cnt_q == CNT_W'(DEPTH);
  wire push = commit && legal && !full;
  wire pop  = deq_valid && deq_ready;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lsa_q <= '0; eah_q <= '0; eal_q <= '0; sztag_q <= '0;
      status_q <= ST_OK;
    end else begin
      if (wr_lsa) lsa_q <= reg_wdata[31:0];
      if (wr_eah) eah_q <= upper_or_lower;
      if (wr_eal) eal_q <= reg_wdata[31:0];
      if (wr_sz)  sztag_q <= upper_or_lower;
      if (commit) status_q <= !legal ? ST_BAD : full ? ST_FULL : ST_OK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      if (push && !pop) cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp_q] <= {lsa_q, eah_q, eal_q, size, sztag_eff[TAG_W-1:0], reg_wdata[31:0]};

  assign deq_valid = cnt_q != '0;
  assign {deq_lsa, deq_ea, deq_size, deq_tag, deq_cmd} = mem[rp_q];
  assign reg_rdata = (reg_addr == 3'd5) ? {30'd0, status_q} : 32'd0;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  p_full_no_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit && full && legal |=> status_q == ST_FULL &&
      cnt_q == $past(cnt_q) - {{(CNT_W-1){1'b0}}, $past(pop)});

  p_reject_keeps_queue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !legal |=> status_q == ST_BAD &&
      cnt_q == $past(cnt_q) - {{(CNT_W-1){1'b0}}, $past(pop)});

  p_accept_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit && legal && !full && !pop |=> status_q == ST_OK && cnt_q == $past(cnt_q) + 1'b1);

  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deq_valid && !deq_ready && !(commit && !full) |=> deq_valid && $stable(deq_lsa) &&
      $stable(deq_tag) && $stable(deq_size));

  p_empty_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !deq_valid |=> cnt_q <= CNT_W'(1));
endmodule

// File: tb/sim_dma_cmd_frontend.sv
module sim_dma_cmd_frontend;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_wide = 0, deq_ready = 0;
  logic [2:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0;
  logic [31:0] reg_rdata, deq_lsa, deq_cmd;
  logic [63:0] deq_ea;
  logic [15:0] deq_size;
  logic [4:0] deq_tag;
  logic deq_valid;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_cmd_frontend u0 (.clk, .rst_n, .reg_wr, .reg_wide, .reg_addr, .reg_wdata, .reg_rdata,
    .deq_valid, .deq_ready, .deq_lsa, .deq_ea, .deq_size, .deq_tag, .deq_cmd);

  // {size, lsa, eal, expected status}
  localparam int NV = 13;
  localparam logic [49:0] VEC [NV] = '{
    {16'd1,     16'h0103, 16'h0007, 2'd0},
    {16'd2,     16'h0102, 16'h0006, 2'd0},
    {16'd2,     16'h0101, 16'h0006, 2'd2},
    {16'd4,     16'h0104, 16'h0009, 2'd2},
    {16'd8,     16'h0108, 16'h0010, 2'd0},
    {16'd3,     16'h0000, 16'h0000, 2'd2},
    {16'd16,    16'h0200, 16'h0030, 2'd0},
    {16'd48,    16'h0210, 16'h0040, 2'd0},
    {16'd24,    16'h0000, 16'h0000, 2'd2},
    {16'd16384, 16'h0000, 16'h0000, 2'd0},
    {16'd16400, 16'h0000, 16'h0000, 2'd2},
    {16'd0,     16'h0000, 16'h0000, 2'd2},
    {16'd32,    16'h0208, 16'h0000, 2'd2}};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d, input logic wide);
    @(negedge clk); reg_wr = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wide = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic take();
    deq_ready = 1; @(negedge clk); deq_ready = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] e_sz [8];
    logic [15:0] e_lsa [8];
    logic [4:0]  e_tag [8];
    logic [31:0] e_eah [8];
    int n = 0;
    repeat (3) @(negedge clk);
    rd(3'd5, r); chk("R1 status", r, 0);
    chk("R1 valid", deq_valid, 0);
    rst_n = 1; @(negedge clk);
    rd(3'd5, r); chk("R1 status after release", r, 0);

    for (int i = 0; i < NV; i++) begin
      wr(3'd0, {48'd0, VEC[i][33:18]}, 0);
      wr(3'd1, {32'hA000_0000 + 32'(i), 16'd0, VEC[i][17:2]}, 1);
      wr(3'd3, {VEC[i][49:34], 16'hFFE0 | 16'(i), 32'hC000_0000 + 32'(i)}, 1);
      rd(3'd5, r);
      chk($sformatf("R4/R5 vector %0d status", i), r, {30'd0, VEC[i][1:0]});
      if (VEC[i][1:0] == 2'd0) begin
        e_sz[n] = VEC[i][49:34]; e_lsa[n] = VEC[i][33:18];
        e_tag[n] = 5'(i); e_eah[n] = 32'hA000_0000 + 32'(i); n++;
      end
    end

    for (int k = 0; k < n; k++) begin
      chk("R8 valid", deq_valid, 1);
      chk("R3 size", deq_size, e_sz[k]);
      chk("R3 lsa", deq_lsa, {16'd0, e_lsa[k]});
      chk("R3 tag low bits", deq_tag, e_tag[k]);
      chk("R2 ea high half", deq_ea[63:32], e_eah[k]);
      take();
    end
    chk("R8 empty after drain", deq_valid, 0);

    // separate 32-bit halves and a commit at index 4
    wr(3'd0, 64'h40, 0);
    wr(3'd1, 64'h1234_5678, 0);
    wr(3'd2, 64'h80, 0);
    wr(3'd3, {32'd0, 16'd64, 16'd7}, 0);
    wr(3'd4, 64'h55AA, 0);
    chk("R2 ea narrow halves", deq_ea, 64'h1234_5678_0000_0080);
    chk("R3 cmd word", deq_cmd, 32'h55AA);
    chk("R3 size narrow", deq_size, 16'd64);
    take();

    for (int k = 0; k < 8; k++) begin
      wr(3'd4, 64'(k), 0);
      rd(3'd5, r); chk("R6 fill", r, 0);
    end
    wr(3'd4, 64'h99, 0);
    rd(3'd5, r); chk("R6 full status", r, 1);
    wr(3'd0, 64'h4, 0);
    wr(3'd4, 64'h98, 0);
    rd(3'd5, r); chk("R7 illegal while full", r, 2);
    wr(3'd5, 64'h0, 0);
    rd(3'd5, r); chk("R9 status write ignored", r, 2);
    rd(3'd0, r); chk("R9 write-only reads 0", r, 0);

    for (int k = 0; k < 8; k++) begin
      chk("R6 entry present", deq_valid, 1);
      chk("R8 order", deq_cmd, 32'(k));
      take();
    end
    chk("R6/R7 no extra entry", deq_valid, 0);

    wr(3'd0, 64'h0, 0);
    wr(3'd4, 64'h1, 0);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    rd(3'd5, r); chk("R1 status after reset", r, 0);
    chk("R1 queue empty after reset", deq_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule